// File: doc/BRIEF.md
# MDIO Management Shift Engine

This block is a station-management master for an Ethernet PHY. Its 32-bit management register is also its shift register. A write while the block is idle loads a complete management frame into that register and starts the shift at once. The block makes the management clock (MDC) by dividing the system clock. On each MDC period the register's most significant bit goes out on MDIO, and one bit sampled from the MDIO line enters at the least significant end. After 32 periods the frame has turned fully around. Every header bit is back where it was written. For a read, the low bits now hold what the PHY drove onto the line.

Software can read the register at any time. While a transfer runs, the readback shows the partly rotated contents. The four leading bits of the written frame mark a read frame. For a read frame the block releases the MDIO output enable once the header has gone out, so the PHY can drive the turnaround and data bits. At completion the block sets a sticky done flag and gives a one-cycle interrupt pulse.

The divider setting is captured when a transfer starts. Setting 3 divides by 64, so one transfer lasts 2048 system clocks.

Top module: `mdio_shift_engine`

## Requirements
- R1: When `wr_en` is high while `busy` is low, `shift_q` equals `wr_data` and `busy` is high after the next clock edge.
- R2: While busy, MDC has a period of 8 << `div_sel` system clocks, low for the first half and high for the second half. The `div_sel` value used is the one present at the start of the transfer; later changes have no effect until the next transfer.
- R3: While busy, `mdio_o` equals bit 31 of `shift_q`. While idle, `mdio_o`, `mdio_oe` and `mdc` are all 0.
- R4: On the clock edge where MDC rises, the block samples the MDIO input. On the clock edge where MDC falls, `shift_q` rotates left by one and the sampled bit enters bit 0. The readback shows this partial state.
- R5: `busy` falls exactly 32 MDC periods after the start. For a frame that does not hand over the bus, `shift_q` then equals the written value.
- R6: A frame whose bits [31:28] are 4'b0110, 4'b0011 or 4'b0010 is a read frame. For a read frame, `mdio_oe` is low from the 15th MDC period to the end. Its final `shift_q` is the written bits [31:18] followed by the 18 bits the PHY drove in periods 15 to 32.
- R7: For any other leading nibble (for example 4'b0101, 4'b0000, 4'b0001), `mdio_oe` stays high for all 32 periods.
- R8: On the cycle `busy` falls, `done` becomes 1 and `irq` is high for exactly that one cycle. `done` clears when the next transfer starts.
- R9: A write while `busy` is high is ignored. The running transfer and its final `shift_q` are unchanged.
- R10: While `rst_n` is low, and after its release until the first write, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Management frame to load |
| div_sel | input | 2 | MDC divider: 0..3 selects /8, /16, /32, /64 |
| mdio_i | input | 1 | Sampled MDIO line |
| shift_q | output | 32 | Live register contents (readback) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The engine runs with a write frame, a clause 22 read, a clause 45 read and a clause 45 read-increment, and with a clause 45 address frame. Each of the four divider settings is used at least once. The PHY model drives a distinct pattern onto the released line. A read that keeps its header and takes in the PHY pattern can therefore be told apart from one that only recirculates its own bits. A write frame coming back unchanged shows that the rotation neither drops nor adds a position. One transfer takes both a write in mid-flight and a change of `div_sel`, which separates latched settings from live ones. A transfer started directly after a completion shows that `done` clears.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;

  // Leading nibbles after which the PHY owns the data line.
  localparam logic [3:0] LEAD_C22_RD  = 4'b0110;
  localparam logic [3:0] LEAD_C45_RD  = 4'b0011;
  localparam logic [3:0] LEAD_C45_RDI = 4'b0010;

  function automatic logic hands_over_bus(input logic [3:0] lead);
    logic r;
    unique case (lead)
      LEAD_C22_RD, LEAD_C45_RD, LEAD_C45_RDI: r = 1'b1;
      default:                                r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mdio_rst_sync.sv
module mdio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign rst_core_n = rst_n;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;
      if (STAGES == 1) begin : g_one
        assign chain_d = 1'b1;
      end else begin : g_many
        assign chain_d = {chain_q[STAGES-2:0], 1'b1};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end
      assign rst_core_n = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_BASE_LOG2 = 3,
  parameter int SEL_W         = 2,
  parameter int CNT_W         = DIV_BASE_LOG2 + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  localparam logic [CNT_W:0] ONE_W = {{CNT_W{1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic [CNT_W:0]   period;
  logic [CNT_W-1:0] full_m1, half_m1;

  always_comb begin
    period    = ONE_W << (DIV_BASE_LOG2 + int'(sel));
    full_m1   = CNT_W'(period - ONE_W);
    half_m1   = CNT_W'((period >> 1) - ONE_W);
    rise_tick = run && (cnt_q == half_m1);
    fall_tick = run && (cnt_q == full_m1);
  end

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else begin
      if (fall_tick) cnt_d = '0;
      else           cnt_d = cnt_q + 1'b1;
      if (rise_tick)      mdc_d = 1'b1;
      else if (fall_tick) mdc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mdio_shift_core.sv
module mdio_shift_core #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_val,
  input  logic               capture,
  input  logic               step,
  input  logic               mdio_i,
  output logic [FRAME_W-1:0] q
);
  logic [FRAME_W-1:0] q_q, q_d;
  logic               samp_q, samp_d;

  always_comb begin
    samp_d = capture ? mdio_i : samp_q;
    if (load)      q_d = load_val;
    else if (step) q_d = {q_q[FRAME_W-2:0], samp_q};
    else           q_d = q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= '0;
      samp_q <= 1'b0;
    end else begin
      q_q    <= q_d;
      samp_q <= samp_d;
    end
  end

  assign q = q_q;
endmodule

// File: rtl/mdio_seq_ctrl.sv
module mdio_seq_ctrl
  import mdio_eng_pkg::*;
#(
  parameter int FRAME_W  = 32,
  parameter int HDR_BITS = 14,
  parameter int SEL_W    = 2,
  parameter int BIT_W    = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_lead,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             fall_tick,
  output logic             load,
  output logic [SEL_W-1:0] div_q,
  output logic             busy,
  output logic             done,
  output logic             irq,
  output logic             oe
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
  localparam logic [BIT_W-1:0] HDR_LIM  = BIT_W'(HDR_BITS);

  logic [BIT_W-1:0] bit_q, bit_d;
  logic             busy_q, busy_d, done_q, done_d, irq_q, irq_d, rd_q, rd_d;
  logic [SEL_W-1:0] div_d, div_r;
  logic             start, last;

  always_comb begin
    start  = wr_en && !busy_q;
    last   = busy_q && fall_tick && (bit_q == LAST_BIT);
    bit_d  = bit_q;
    if (start)                    bit_d = '0;
    else if (busy_q && fall_tick) bit_d = bit_q + 1'b1;
    busy_d = start ? 1'b1 : (last ? 1'b0 : busy_q);
    done_d = start ? 1'b0 : (last ? 1'b1 : done_q);
    irq_d  = last;
    rd_d   = start ? hands_over_bus(wr_lead) : rd_q;
    div_d  = start ? div_sel : div_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      rd_q   <= 1'b0;
      div_r  <= '0;
    end else begin
      bit_q  <= bit_d;
      busy_q <= busy_d;
      done_q <= done_d;
      irq_q  <= irq_d;
      rd_q   <= rd_d;
      div_r  <= div_d;
    end
  end

  assign load  = start;
  assign div_q = div_r;
  assign busy  = busy_q;
  assign done  = done_q;
  assign irq   = irq_q;
  assign oe    = busy_q && (!rd_q || (bit_q < HDR_LIM));
endmodule

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine #(
  parameter int FRAME_W       = 32,
  parameter int HDR_BITS      = 14,
  parameter int DIV_BASE_LOG2 = 3,
  parameter int SEL_W         = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FRAME_W-1:0] wr_data,
  input  logic [SEL_W-1:0]   div_sel,
  input  logic               mdio_i,
  output logic [FRAME_W-1:0] shift_q,
  output logic               busy,
  output logic               done,
  output logic               irq,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe
);
  localparam int CNT_W = DIV_BASE_LOG2 + (1 << SEL_W) - 1;

  logic             rst_core_n;
  logic             load, rise_tick, fall_tick, oe;
  logic [SEL_W-1:0] div_q;

  mdio_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  mdio_seq_ctrl #(
    .FRAME_W(FRAME_W), .HDR_BITS(HDR_BITS), .SEL_W(SEL_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en),
    .wr_lead(wr_data[FRAME_W-1 -: 4]), .div_sel(div_sel),
    .fall_tick(fall_tick), .load(load), .div_q(div_q),
    .busy(busy), .done(done), .irq(irq), .oe(oe)
  );

  mdio_clk_div #(
    .DIV_BASE_LOG2(DIV_BASE_LOG2), .SEL_W(SEL_W), .CNT_W(CNT_W)
  ) u_div (
    .clk(clk), .rst_n(rst_core_n), .run(busy), .sel(div_q),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_shift_core #(.FRAME_W(FRAME_W)) u_core (
    .clk(clk), .rst_n(rst_core_n), .load(load), .load_val(wr_data),
    .capture(rise_tick), .step(fall_tick), .mdio_i(mdio_i), .q(shift_q)
  );

  assign mdio_o  = busy && shift_q[FRAME_W-1];
  assign mdio_oe = oe;
endmodule

// File: rtl/mdio_shift_engine_chk.sv
module mdio_shift_engine_chk #(
  parameter int FRAME_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [FRAME_W-1:0] wr_data,
  input logic [FRAME_W-1:0] shift_q,
  input logic               busy,
  input logic               done,
  input logic               irq,
  input logic               mdc,
  input logic               mdio_o,
  input logic               mdio_oe
);
  a_r1_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en) |=> (busy && shift_q == $past(wr_data)));

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_o && !mdio_oe));

  a_r5_end_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && irq));

  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r8_irq_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && !busy));

  a_r8_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done);

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !$rose(busy)) |=> (busy || irq));
endmodule

bind mdio_shift_engine mdio_shift_engine_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .shift_q(shift_q), .busy(busy), .done(done), .irq(irq), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_shift_engine_bench.sv
module mdio_shift_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [1:0]  div_sel;
  logic        mdio_i;
  logic [31:0] shift_q;
  logic        busy, done, irq, mdc, mdio_o, mdio_oe;

  mdio_shift_engine u_mdio_shift_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .div_sel(div_sel), .mdio_i(mdio_i), .shift_q(shift_q), .busy(busy),
    .done(done), .irq(irq), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  // behavioural reference
  bit          m_busy = 0, m_done = 0, m_irq = 0, m_rd = 0, m_samp = 0;
  int          m_t = 0, m_n = 8;
  logic [31:0] m_reg = '0;
  logic [31:0] phy_word = 32'h0;
  logic        phy_drv = 1'b1;
  logic        line_prev = 1'b0;
  bit          model_on = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : phy_drv;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  function automatic bit is_rd(input logic [3:0] lead);
    return lead == 4'b0110 || lead == 4'b0011 || lead == 4'b0010;
  endfunction

  always @(posedge clk) begin
    if (model_on) begin
      if (!m_busy) begin
        m_irq = 0;
        if (wr_en) begin
          m_busy = 1; m_t = 0; m_reg = wr_data; m_done = 0;
          m_n = 8 << div_sel; m_rd = is_rd(wr_data[31:28]);
        end
      end else begin
        m_t++;
        m_irq = 0;
        if (m_t % m_n == m_n / 2) m_samp = line_prev;
        if (m_t % m_n == 0) begin
          m_reg = {m_reg[30:0], m_samp};
          if (m_t == 32 * m_n) begin
            m_busy = 0; m_done = 1; m_irq = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    line_prev = mdio_i;
    phy_drv   = m_busy ? phy_word[31 - (m_t / m_n)] : 1'b1;
    if (model_on) begin
      chk(shift_q == m_reg, "R4 readback", shift_q, m_reg);
      chk(mdc == (m_busy && (m_t % m_n) >= m_n / 2), "R2 mdc", {31'b0, mdc},
          {31'b0, m_busy && (m_t % m_n) >= m_n / 2});
      chk(mdio_o == (m_busy && m_reg[31]), "R3 mdio_o", {31'b0, mdio_o},
          {31'b0, m_busy && m_reg[31]});
      chk(mdio_oe == (m_busy && (!m_rd || (m_t / m_n) < 14)), "R6 oe",
          {31'b0, mdio_oe}, {31'b0, m_busy && (!m_rd || (m_t / m_n) < 14)});
      chk(busy == m_busy, "R5 busy", {31'b0, busy}, {31'b0, m_busy});
      chk(done == m_done, "R8 done", {31'b0, done}, {31'b0, m_done});
      chk(irq == m_irq, "R8 irq", {31'b0, irq}, {31'b0, m_irq});
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // Starts one transfer and checks R1 one edge later.
  task automatic start_op(input logic [31:0] data, input logic [1:0] sel,
                          input logic [31:0] pw);
    wait_idle();
    phy_word = pw;
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = data; div_sel = sel;
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk(busy && shift_q == data, "R1 load", shift_q, data);
    chk(!done, "R8 done cleared at start", {31'b0, done}, 32'h0);
  endtask

  task automatic finish_op(input logic [31:0] exp, input string req);
    wait_idle();
    chk(shift_q == exp, req, shift_q, exp);
    chk(done && irq, "R8 done and irq at end", {30'b0, done, irq}, 32'h3);
    @(negedge clk);
    chk(!irq && done, "R8 irq single pulse", {30'b0, done, irq}, 32'h2);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 32'h0; div_sel = 2'd0;
    repeat (4) @(negedge clk);
    chk({shift_q, busy, done, irq, mdc, mdio_o, mdio_oe} == '0,
        "R10 outputs in reset", shift_q, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({shift_q, busy, done, irq, mdc, mdio_o, mdio_oe} == '0,
        "R10 outputs after release", shift_q, 32'h0);
    model_on = 1;

    // R7: clause 22 write keeps the line; R5 value returns unchanged
    start_op(32'h5A4B_C3D2, 2'd0, 32'hFFFF_0000);
    finish_op(32'h5A4B_C3D2, "R5 write frame returns unchanged");

    // R6: clause 22 read, PHY pattern replaces bits 17:0
    start_op(32'h6123_0000, 2'd1, 32'h0003_A5C3);
    finish_op({16'h6123 & 16'hFFFC, 16'h0} | 32'h0003_A5C3 & 32'h0003_FFFF
              | (32'h6123_0000 & 32'hFFFC_0000), "R6 c22 read data lands");

    // R9 + R2: clause 45 read with a write and a divider change mid-flight
    start_op(32'h3FC0_0000, 2'd2, 32'h0001_2345);
    repeat (300) @(negedge clk);
    #1;
    wr_en = 1'b1; wr_data = 32'h5555_5555; div_sel = 2'd0;
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk(busy, "R9 write during busy ignored", {31'b0, busy}, 32'h1);
    finish_op((32'h3FC0_0000 & 32'hFFFC_0000) | (32'h0001_2345 & 32'h0003_FFFF),
              "R9 R6 c45 read result untouched by late write");

    // R7: clause 45 address frame at the slowest divider
    start_op(32'h0A5F_0F0F, 2'd3, 32'h0000_0000);
    finish_op(32'h0A5F_0F0F, "R7 c45 address frame keeps line");

    // R6: clause 45 read-increment, back to back after completion
    start_op(32'h2BCD_FFFF, 2'd0, 32'hFFFE_1111);
    finish_op((32'h2BCD_FFFF & 32'hFFFC_0000) | (32'hFFFE_1111 & 32'h0003_FFFF),
              "R6 c45 read-increment");

    // R7: clause 45 write frame
    start_op(32'h1234_8001, 2'd1, 32'h0);
    finish_op(32'h1234_8001, "R7 c45 write frame keeps line");

    repeat (4) @(negedge clk);
    chk(done && !busy && !mdc && !mdio_oe, "R3 idle quiet after run",
        {28'b0, done, busy, mdc, mdio_oe}, 32'h8);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule